// File: doc/BRIEF.md
# Gated Shift-Clock Divider

This block divides a pixel-rate clock in two stages. The first stage counts pixel clocks against a programmable modulus and produces a load strobe with a roughly even duty cycle. The second stage counts whole load periods against its own modulus and produces a secondary output. Downstream logic can use that output as a horizontal reset for the display pipeline.

If the second-stage modulus is 1, the secondary output becomes a copy of the load strobe, with the same cycle and the same phase. In this copy mode, the shift-clock enable lets a blanking input start and stop the copy. Changes in blanking are taken up only while the strobe is low. As a result, the copy never carries a cut-short pulse, and it always stops at a low level.

Both outputs are registered. Every width is a parameter. Moduli are applied on the fly, and a counter wraps as soon as its count reaches the current modulus minus one.

Top module: `shift_clk_div`

## Requirements
- R1: While rst_ni is low, load_o and aux_o are 0 and both counters are cleared.
- R2: The first-stage modulus M1 is the value of n1_div_i, where values below 2 count as 2. load_o repeats every M1 clocks. In each period it is high for floor(M1/2) cycles at the start and low for the rest.
- R3: If n2_div_i is M2 ≥ 2, aux_o repeats every M1·M2 clocks. It is high for the first floor(M2/2) load periods of each cycle, and it rises in the same cycle as load_o. sc_en_i and blank_i have no effect on aux_o in this case.
- R4: If n2_div_i ≤ 1 (0 counts as 1) and sc_en_i is 0, aux_o equals load_o in every cycle, and blank_i is ignored.
- R5: If n2_div_i ≤ 1 and sc_en_i is 1, aux_o equals load_o AND a gate bit. The gate bit takes the blank_i level sampled at each clock edge after which load_o is low. It keeps its value at edges after which load_o is high. blank_i = 1 lets the copy run; blank_i = 0 stops it.
- R6: In the gated mode of R5, every high pulse of aux_o starts and ends in the same cycles as a load_o pulse, so each pulse lasts exactly floor(M1/2) cycles.
- R7: If n2_div_i ≤ 1, aux_o is never high while load_o is low, so the output always parks low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| n1_div_i | input | N1_W | First-stage modulus |
| n2_div_i | input | N2_W | Second-stage modulus, ≤1 selects copy mode |
| sc_en_i | input | 1 | Shift-clock enable: lets blank_i gate the copy |
| blank_i | input | 1 | 1 runs the copy, 0 stops it low |
| load_o | output | 1 | Divided load strobe |
| aux_o | output | 1 | Second-stage output or gated load copy |

## Verification
The risky coincidence is a blanking edge that arrives in the same cycle as a load-strobe edge. A naive gate would cut a pulse short or start one late. The bench holds copy mode with the shift-clock enable set and toggles blank_i at random, one sample per clock, so transitions land on every phase of the strobe, including its rising and falling cycles. Each cycle, the outputs are compared with a reference model that only lets blanking take effect after edges where the strobe is low. The bench also measures every aux_o high pulse and checks that its width matches the strobe's high time.

// File: rtl/shift_clk_div_pkg.sv
package shift_clk_div_pkg;
  typedef enum logic [1:0] {
    AUX_DIV   = 2'd0,
    AUX_COPY  = 2'd1,
    AUX_GATED = 2'd2
  } aux_src_e;
endpackage

// File: rtl/shift_clk_div_stage.sv
module shift_clk_div_stage #(
  parameter int W       = 8,
  parameter int MIN_MOD = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic [W-1:0] mod_i,
  output logic         out_nxt_o,
  output logic         wrap_nxt_o
);
  localparam logic [W-1:0] MinMod = W'(MIN_MOD);

  logic [W-1:0] eff_mod, half_mod, cnt_q, cnt_d;

  assign eff_mod  = (mod_i < MinMod) ? MinMod : mod_i;
  assign half_mod = eff_mod >> 1;

  always_comb begin
    wrap_nxt_o = adv_i && (cnt_q >= eff_mod - W'(1));
    cnt_d      = cnt_q;
    if (adv_i) cnt_d = wrap_nxt_o ? '0 : cnt_q + W'(1);
  end

  // high phase first; odd modulus leaves the shorter half high
  assign out_nxt_o = cnt_d < half_mod;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/shift_clk_div_gate.sv
module shift_clk_div_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_nxt_i,
  input  logic blank_i,
  output logic gate_nxt_o
);
  logic gate_q;

  // blank is only taken while the strobe will be low
  assign gate_nxt_o = load_nxt_i ? gate_q : blank_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_nxt_o;
  end
endmodule

// File: rtl/shift_clk_div.sv
module shift_clk_div
  import shift_clk_div_pkg::*;
#(
  parameter int N1_W = 8,
  parameter int N2_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N1_W-1:0] n1_div_i,
  input  logic [N2_W-1:0] n2_div_i,
  input  logic            sc_en_i,
  input  logic            blank_i,
  output logic            load_o,
  output logic            aux_o
);
  logic     load_nxt, s1_wrap_nxt, div2_nxt, s2_wrap_nxt, gate_nxt, aux_nxt;
  logic     load_q, aux_q;
  aux_src_e aux_src;

  shift_clk_div_stage #(.W(N1_W), .MIN_MOD(2)) u_stage1 (
    .clk_i, .rst_ni,
    .adv_i      (1'b1),
    .mod_i      (n1_div_i),
    .out_nxt_o  (load_nxt),
    .wrap_nxt_o (s1_wrap_nxt)
  );

  // second stage advances once per load period
  shift_clk_div_stage #(.W(N2_W), .MIN_MOD(1)) u_stage2 (
    .clk_i, .rst_ni,
    .adv_i      (s1_wrap_nxt),
    .mod_i      (n2_div_i),
    .out_nxt_o  (div2_nxt),
    .wrap_nxt_o (s2_wrap_nxt)
  );

  shift_clk_div_gate u_gate (
    .clk_i, .rst_ni,
    .load_nxt_i (load_nxt),
    .blank_i,
    .gate_nxt_o (gate_nxt)
  );

  always_comb begin
    if (n2_div_i > N2_W'(1)) aux_src = AUX_DIV;
    else if (sc_en_i)        aux_src = AUX_GATED;
    else                     aux_src = AUX_COPY;
  end

  always_comb begin
    unique case (aux_src)
      AUX_COPY:  aux_nxt = load_nxt;
      AUX_GATED: aux_nxt = load_nxt & gate_nxt;
      default:   aux_nxt = div2_nxt;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      aux_q  <= 1'b0;
    end else begin
      load_q <= load_nxt;
      aux_q  <= aux_nxt;
    end
  end

  assign load_o = load_q;
  assign aux_o  = aux_q;

  logic unused_wrap;
  assign unused_wrap = s2_wrap_nxt;
endmodule

// File: rtl/shift_clk_div_chk.sv
module shift_clk_div_chk #(
  parameter int N2_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N2_W-1:0] n2_div_i,
  input logic            sc_en_i,
  input logic            load_o,
  input logic            aux_o
);
  logic copy_mode, gated_mode;
  assign copy_mode  = n2_div_i <= N2_W'(1);
  assign gated_mode = copy_mode && sc_en_i;

  // R1
  reset_low_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!load_o && !aux_o));

  // R4
  copy_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(copy_mode && !sc_en_i) |-> (aux_o == load_o));

  // R7
  park_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(copy_mode) |-> (!aux_o || load_o));

  // R6
  gated_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(aux_o) && $past(gated_mode) && $past(gated_mode, 2)) |-> $rose(load_o));

  // R6
  gated_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(aux_o) && $past(gated_mode) && $past(gated_mode, 2)) |-> $fell(load_o));
endmodule

bind shift_clk_div shift_clk_div_chk #(.N2_W(N2_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .n2_div_i (n2_div_i),
  .sc_en_i  (sc_en_i),
  .load_o   (load_o),
  .aux_o    (aux_o)
);

// File: tb/shift_clk_div_tb.sv
module shift_clk_div_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N1_W = 8;
  localparam int N2_W = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b1;
  logic [N1_W-1:0] n1_div_i = 8'd5;
  logic [N2_W-1:0] n2_div_i = 8'd3;
  logic            sc_en_i = 1'b0;
  logic            blank_i = 1'b0;
  logic            load_o, aux_o;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  shift_clk_div #(.N1_W(N1_W), .N2_W(N2_W)) u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference model
  int  p1 = 0, p2 = 0, e1, e2;
  bit  g = 0, exp_load = 0, exp_aux = 0, wrap;
  string aux_tag = "R1", load_tag = "R1";

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1 = 0; p2 = 0; g = 0; exp_load = 0; exp_aux = 0;
      aux_tag = "R1"; load_tag = "R1";
    end else begin
      e1 = (int'(n1_div_i) < 2) ? 2 : int'(n1_div_i);
      e2 = (int'(n2_div_i) < 1) ? 1 : int'(n2_div_i);
      wrap = (p1 >= e1 - 1);
      p1 = wrap ? 0 : p1 + 1;
      if (wrap) p2 = (p2 >= e2 - 1) ? 0 : p2 + 1;
      exp_load = (p1 < e1 / 2);
      if (!exp_load) g = blank_i;
      load_tag = "R2";
      if (e2 == 1) begin
        exp_aux = sc_en_i ? (exp_load && g) : exp_load;
        aux_tag = sc_en_i ? "R5" : "R4";
      end else begin
        exp_aux = (p2 < e2 / 2);
        aux_tag = "R3";
      end
    end
  end

  task automatic check(string tag, bit act, bit exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle compare plus pulse-width measurement for R6
  bit r6_arm = 0;
  int r6_half = 0, run = 0;
  always @(negedge clk_i) begin
    if (!done) begin
      check(load_tag, load_o, exp_load, "load_o");
      check(aux_tag, aux_o, exp_aux, "aux_o");
      if (aux_o === 1'b1) run++;
      else begin
        if (r6_arm && run > 0) begin
          n_checks++;
          if (run != r6_half) begin
            n_fail++;
            $display("FAIL R6 pulse width: actual %0d expected %0d", run, r6_half);
          end
        end
        run = 0;
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    #(CLK_PERIOD/4);
  endtask

  task automatic set_mode(int m1, int m2, bit sc);
    n1_div_i = N1_W'(m1);
    n2_div_i = N2_W'(m2);
    sc_en_i  = sc;
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    step(3);
    // R1 reset state
    check("R1", load_o, 1'b0, "load_o in reset");
    check("R1", aux_o, 1'b0, "aux_o in reset");
    rst_ni = 1'b1;

    // R3 divided output, blank and sc_en toggled
    set_mode(5, 3, 0);
    for (int i = 0; i < 150; i++) begin blank_i = i[2]; step(1); end
    set_mode(7, 2, 1);
    for (int i = 0; i < 150; i++) begin blank_i = i[3]; step(1); end

    // R4 plain copy, blank ignored
    set_mode(4, 1, 0);
    for (int i = 0; i < 120; i++) begin blank_i = i[1]; step(1); end
    set_mode(3, 0, 0);
    for (int i = 0; i < 60; i++) begin blank_i = i[0]; step(1); end

    // R5, R6, R7 gated copy with random blank on every phase
    set_mode(6, 1, 1);
    r6_half = 3;
    blank_i = 1'b1;
    step(20);
    r6_arm = 1;
    for (int i = 0; i < 2000; i++) begin blank_i = 1'($urandom); step(1); end
    // R5 long blank low: copy held low
    blank_i = 1'b0;
    step(30);
    check("R5", aux_o, 1'b0, "aux_o held low while blanked");
    blank_i = 1'b1;
    step(30);
    r6_arm = 0;

    // R2 boundary: modulus below 2 behaves as 2, odd modulus
    set_mode(0, 1, 1);
    for (int i = 0; i < 200; i++) begin blank_i = 1'($urandom); step(1); end
    set_mode(9, 1, 1);
    r6_half = 4;
    step(20);
    r6_arm = 1;
    for (int i = 0; i < 600; i++) begin blank_i = 1'($urandom); step(1); end
    r6_arm = 0;

    // R1 mid-run reset
    rst_ni = 1'b0;
    step(2);
    check("R1", load_o, 1'b0, "load_o after mid reset");
    check("R1", aux_o, 1'b0, "aux_o after mid reset");
    rst_ni = 1'b1;
    set_mode(5, 4, 0);
    step(100);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule